// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This block is a control state machine that sits between a converter's power-down controls and its calibration engine. It decides when a calibration may start, whether the Q channel takes part in it, when each channel's supply may be switched off, and when output data from the pipeline can be trusted again. The calibration algorithm and the analog power switches are not part of it. It drives a one-cycle start pulse to the engine and waits for a one-cycle done strobe back.

After reset the sequencer waits for the power-good indication. The power-on calibration starts only once the global power-down input is low. A power-down request that arrives while a calibration is running is held off until the engine reports completion. A manual calibration request is taken on its rising edge, and only when the device is powered and idle. A request made during power-down is discarded. The Q channel has its own power-down input, and it is left out of any calibration that starts while it is off. A sticky flag reports that Q was powered up after a calibration that did not include it.

After any channel's power enable rises, the pipeline-valid output is held low for a programmable number of cycles, 13 by default, which matches the output latency.

Top module: `pdcal_seq`

## Requirements
- R1: While `rst` is high, and on the first rising clock edge with it high, every output is driven low.
- R2: In the waiting state, with `pwr_good` high and `pd_all` low at a clock edge, `cal_start` is high for exactly one cycle after that edge. From the same edge `cal_en_i` and `pwr_en_i` are high.
- R3: While `pd_all` is high in the waiting state, no calibration starts and both channels stay unpowered.
- R4: A `cal_done` strobe during a calibration lowers `cal_en_i` and `cal_en_q` from the next edge. Power stays on if `pd_all` is low.
- R5: `pd_all` high while idle and powered lowers `pwr_en_i` and `pwr_en_q` from the next edge.
- R6: `pd_all` high during a calibration leaves both power enables high until the edge that samples `cal_done`. From that edge they are low. This also applies when `pd_all` and `cal_done` rise together.
- R7: A manual calibration starts only on a 0-to-1 change of `cal_req` while idle and powered. Holding `cal_req` high starts no second calibration.
- R8: A `cal_req` rising edge while powered down is discarded. When power returns with `cal_req` still high, no calibration starts.
- R9: `pd_q` high lowers only `pwr_en_q` and leaves `pwr_en_i` unchanged. `pwr_en_q` is never high while `pwr_en_i` is low.
- R10: A calibration that starts while `pd_q` is high, or during which `pd_q` goes high, keeps `cal_en_q` low while `cal_en_i` is high.
- R11: After a rising edge of `pwr_en_i` or `pwr_en_q`, `pipe_valid` is low in that cycle and the next HOLDOFF_CYC-1 cycles. It is high in the cycle after those. It is low whenever `pwr_en_i` is low.
- R12: `q_recal` goes high when `pwr_en_q` rises after the last completed calibration excluded Q. It goes low when a calibration that included Q completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply is up (power-on indication) |
| pd_all | input | 1 | Global power-down request, high = down |
| pd_q | input | 1 | Q-channel power-down request, high = down |
| cal_req | input | 1 | Manual calibration request, taken on its rising edge |
| cal_done | input | 1 | One-cycle completion strobe from the calibration engine |
| cal_start | output | 1 | One-cycle start pulse to the calibration engine |
| cal_en_i | output | 1 | I channel is being calibrated |
| cal_en_q | output | 1 | Q channel is being calibrated |
| pwr_en_i | output | 1 | I channel power enable |
| pwr_en_q | output | 1 | Q channel power enable |
| pipe_valid | output | 1 | Pipeline output data is meaningful |
| q_recal | output | 1 | Q channel needs a new calibration |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `cal_done` is a single-cycle strobe that arrives only while a calibration is running. An early or repeated strobe would be taken as a real completion and would end a calibration before its time. The bench drives every input at the falling clock edge. It pulses `cal_done` only from its own counter-based engine or from vector rows that follow a start, so the stimulus stays within these assumptions.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;
  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_CAL    = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_PDPEND = 3'd3,
    ST_PDOWN  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic pd_all,
  input  logic pd_q,
  input  logic cal_req,
  input  logic cal_done,
  output logic cal_start_o,
  output logic cal_en_i_o,
  output logic cal_en_q_o,
  output logic pwr_i_o,
  output logic pwr_q_o,
  output logic pwr_i_nxt_o,
  output logic pwr_q_nxt_o,
  output logic finish_o,
  output logic finish_q_incl_o
);
  seq_state_e state_q, state_d;
  logic req_d_q;
  logic q_incl_q, q_incl_d;
  logic start_now, req_rise, cal_busy;
  logic cal_nxt, cal_q_nxt;
  logic cal_start_q, cal_en_i_q, cal_en_q_q, pwr_i_q, pwr_q_q;

  assign req_rise = cal_req && !req_d_q;
  assign cal_busy = (state_q == ST_CAL) || (state_q == ST_PDPEND);

  always_comb begin
    state_d   = state_q;
    start_now = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (pwr_good && !pd_all) begin
          state_d   = ST_CAL;
          start_now = 1'b1;
        end
      end
      ST_CAL: begin
        if (cal_done) state_d = pd_all ? ST_PDOWN : ST_ACTIVE;
        else if (pd_all) state_d = ST_PDPEND;
      end
      ST_PDPEND: begin
        if (cal_done) state_d = pd_all ? ST_PDOWN : ST_ACTIVE;
        else if (!pd_all) state_d = ST_CAL;
      end
      ST_ACTIVE: begin
        if (pd_all) state_d = ST_PDOWN;
        else if (req_rise) begin
          state_d   = ST_CAL;
          start_now = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (!pd_all) state_d = ST_ACTIVE;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  // Q takes part only if it was up at the start and stayed up throughout.
  assign q_incl_d    = start_now ? !pd_q : (q_incl_q && !pd_q);
  assign cal_nxt     = (state_d == ST_CAL) || (state_d == ST_PDPEND);
  assign cal_q_nxt   = cal_nxt && q_incl_d;
  assign pwr_i_nxt_o = (state_d == ST_CAL) || (state_d == ST_ACTIVE) || (state_d == ST_PDPEND);
  assign pwr_q_nxt_o = pwr_i_nxt_o && !pd_q;

  assign finish_o        = cal_busy && cal_done;
  assign finish_q_incl_o = q_incl_q && !pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_WAIT;
      req_d_q     <= 1'b0;
      q_incl_q    <= 1'b0;
      cal_start_q <= 1'b0;
      cal_en_i_q  <= 1'b0;
      cal_en_q_q  <= 1'b0;
      pwr_i_q     <= 1'b0;
      pwr_q_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      req_d_q     <= cal_req;
      q_incl_q    <= q_incl_d;
      cal_start_q <= start_now;
      cal_en_i_q  <= cal_nxt;
      cal_en_q_q  <= cal_q_nxt;
      pwr_i_q     <= pwr_i_nxt_o;
      pwr_q_q     <= pwr_q_nxt_o;
    end
  end

  assign cal_start_o = cal_start_q;
  assign cal_en_i_o  = cal_en_i_q;
  assign cal_en_q_o  = cal_en_q_q;
  assign pwr_i_o     = pwr_i_q;
  assign pwr_q_o     = pwr_q_q;

  // R2
  cal_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start_q |=> !cal_start_q);
  // R3
  wait_pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && pd_all) |=> (!cal_start_q && !pwr_i_q));
  // R5
  pd_active_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && pd_all) |=> (!pwr_i_q && !pwr_q_q));
  // R6
  defer_pd_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && !cal_done) |=> pwr_i_q);
  // R8
  pdown_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDOWN) |=> !cal_start_q);
  // R9
  q_under_i_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_q_q |-> pwr_i_q);
  // R10
  cal_q_subset_chk: assert property (@(posedge clk) disable iff (rst)
    cal_en_q_q |-> (cal_en_i_q && pwr_q_q));
endmodule

// File: rtl/pdcal_holdoff.sv
module pdcal_holdoff #(
  parameter int LAT = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i_nxt,
  input  logic en_q_nxt,
  input  logic en_i_cur,
  input  logic en_q_cur,
  output logic valid_o
);
  logic rise;
  assign rise = (en_i_nxt && !en_i_cur) || (en_q_nxt && !en_q_cur);

  generate
    if (LAT == 0) begin : g_direct
      logic valid_q;
      always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= en_i_nxt;
      end
      assign valid_o = valid_q;
    end else begin : g_count
      localparam int CNT_W = $clog2(LAT + 1);
      logic [CNT_W-1:0] cnt_q;
      logic valid_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q   <= '0;
          valid_q <= 1'b0;
        end else if (rise) begin
          cnt_q   <= CNT_W'(LAT - 1);
          valid_q <= 1'b0;
        end else begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          valid_q <= en_i_nxt && (cnt_q == '0);
        end
      end
      assign valid_o = valid_q;

      // R11
      holdoff_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> !valid_q);
      // R11
      rise_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !valid_q);
    end
  endgenerate

  // R11
  valid_needs_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> en_i_cur);
endmodule

// File: rtl/pdcal_qtrack.sv
module pdcal_qtrack (
  input  logic clk,
  input  logic rst,
  input  logic finish,
  input  logic finish_q_incl,
  input  logic q_nxt,
  input  logic q_cur,
  output logic flag_o
);
  logic excl_q, flag_q, excl_eff, q_rise;

  assign excl_eff = finish ? !finish_q_incl : excl_q;
  assign q_rise   = q_nxt && !q_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      excl_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (finish) excl_q <= !finish_q_incl;
      if (finish && finish_q_incl) flag_q <= 1'b0;
      else if (q_rise && excl_eff) flag_q <= 1'b1;
    end
  end
  assign flag_o = flag_q;

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (finish && finish_q_incl) |=> !flag_q);
  // R12
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (q_rise && excl_q && !finish) |=> flag_q);
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
  parameter int HOLDOFF_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic pd_all,
  input  logic pd_q,
  input  logic cal_req,
  input  logic cal_done,
  output logic cal_start,
  output logic cal_en_i,
  output logic cal_en_q,
  output logic pwr_en_i,
  output logic pwr_en_q,
  output logic pipe_valid,
  output logic q_recal
);
  logic pwr_i_nxt, pwr_q_nxt, finish, finish_q_incl;

  pdcal_fsm i_fsm (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .pd_all(pd_all), .pd_q(pd_q),
    .cal_req(cal_req), .cal_done(cal_done),
    .cal_start_o(cal_start), .cal_en_i_o(cal_en_i), .cal_en_q_o(cal_en_q),
    .pwr_i_o(pwr_en_i), .pwr_q_o(pwr_en_q),
    .pwr_i_nxt_o(pwr_i_nxt), .pwr_q_nxt_o(pwr_q_nxt),
    .finish_o(finish), .finish_q_incl_o(finish_q_incl)
  );

  pdcal_holdoff #(.LAT(HOLDOFF_CYC)) i_holdoff (
    .clk(clk), .rst(rst),
    .en_i_nxt(pwr_i_nxt), .en_q_nxt(pwr_q_nxt),
    .en_i_cur(pwr_en_i), .en_q_cur(pwr_en_q),
    .valid_o(pipe_valid)
  );

  pdcal_qtrack i_qtrack (
    .clk(clk), .rst(rst), .finish(finish), .finish_q_incl(finish_q_incl),
    .q_nxt(pwr_q_nxt), .q_cur(pwr_en_q), .flag_o(q_recal)
  );

  // R4
  done_ends_cal_chk: assert property (@(posedge clk) disable iff (rst)
    (finish && !pd_all) |=> (!cal_en_i && !cal_en_q && pwr_en_i));
endmodule

// File: tb/test_pdcal_seq.sv
module test_pdcal_seq;
  localparam int HOLD = 13;
  localparam int NV = 26;
  // bits [10:6]: pwr_good pd_all pd_q cal_req cal_done
  // bits [5:0] : cal_start cal_en_i cal_en_q pwr_en_i pwr_en_q q_recal
  localparam logic [10:0] VECS [NV] = '{
    11'b00000_000000, 11'b11000_000000, 11'b11000_000000, 11'b10000_111110,
    11'b10000_011110, 11'b10001_000110, 11'b10000_000110, 11'b10010_111110,
    11'b10010_011110, 11'b10011_000110, 11'b10010_000110, 11'b10000_000110,
    11'b10100_000100, 11'b10110_110100, 11'b11110_010100, 11'b11100_010100,
    11'b11101_000000, 11'b11100_000000, 11'b11110_000000, 11'b10110_000100,
    11'b10010_000111, 11'b10000_000111, 11'b10010_111111, 11'b10011_000110,
    11'b11000_000000, 11'b10000_000110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b0, pd_all = 1'b0, pd_q = 1'b0, cal_req = 1'b0, cal_done = 1'b0;
  logic cal_start, cal_en_i, cal_en_q, pwr_en_i, pwr_en_q, pipe_valid, q_recal;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pdcal_seq #(.HOLDOFF_CYC(HOLD)) i_pdcal_seq (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .pd_all(pd_all), .pd_q(pd_q),
    .cal_req(cal_req), .cal_done(cal_done), .cal_start(cal_start),
    .cal_en_i(cal_en_i), .cal_en_q(cal_en_q), .pwr_en_i(pwr_en_i),
    .pwr_en_q(pwr_en_q), .pipe_valid(pipe_valid), .q_recal(q_recal)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // calibration engine: a counter of programmable length, strobes done at its end
  task automatic run_cal(int len);
    for (int k = 1; k <= len; k++) begin
      cal_done = (k == len);
      tick();
    end
    cal_done = 1'b0;
  endtask

  function automatic string row_req(int r);
    if (r <= 2)  return "R3";
    if (r <= 4)  return "R2";
    if (r <= 6)  return "R4";
    if (r <= 11) return "R7";
    if (r == 12) return "R9";
    if (r == 13) return "R10";
    if (r <= 16) return "R6";
    if (r <= 19) return "R8";
    if (r <= 23) return "R12";
    return "R5";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 cal_start", cal_start, 1'b0);
    chk("R1 cal_en_i", cal_en_i, 1'b0);
    chk("R1 pwr_en_i", pwr_en_i, 1'b0);
    chk("R1 pipe_valid", pipe_valid, 1'b0);
    rst = 1'b0;

    for (int r = 0; r < NV; r++) begin
      {pwr_good, pd_all, pd_q, cal_req, cal_done} = VECS[r][10:6];
      tick();
      chk($sformatf("%s row %0d cal_start", row_req(r), r), cal_start, VECS[r][5]);
      chk($sformatf("%s row %0d cal_en_i", row_req(r), r), cal_en_i, VECS[r][4]);
      chk($sformatf("%s row %0d cal_en_q", row_req(r), r), cal_en_q, VECS[r][3]);
      chk($sformatf("%s row %0d pwr_en_i", row_req(r), r), pwr_en_i, VECS[r][2]);
      chk($sformatf("%s row %0d pwr_en_q", row_req(r), r), pwr_en_q, VECS[r][1]);
      chk($sformatf("%s row %0d q_recal", row_req(r), r), q_recal, VECS[r][0]);
    end

    // R1: reset in the middle of operation
    rst = 1'b1; cal_req = 1'b0; pd_q = 1'b0; pd_all = 1'b0;
    tick();
    chk("R1 mid cal_start", cal_start, 1'b0);
    chk("R1 mid pwr_en_i", pwr_en_i, 1'b0);
    chk("R1 mid pwr_en_q", pwr_en_q, 1'b0);
    chk("R1 mid q_recal", q_recal, 1'b0);
    chk("R1 mid pipe_valid", pipe_valid, 1'b0);
    rst = 1'b0; pwr_good = 1'b1;

    // R11: holdoff after power-on
    tick();
    chk("R2 start pulse", cal_start, 1'b1);
    chk("R11 valid low at rise", pipe_valid, 1'b0);
    for (int k = 1; k < HOLD; k++) begin
      tick();
      chk($sformatf("R11 valid low +%0d", k), pipe_valid, 1'b0);
    end
    tick();
    chk("R11 valid high after holdoff", pipe_valid, 1'b1);
    run_cal(4);
    chk("R4 engine done cal_en_i", cal_en_i, 1'b0);
    chk("R4 engine done pwr_en_i", pwr_en_i, 1'b1);

    // R11: Q re-power restarts holdoff
    pd_q = 1'b1; tick();
    chk("R11 valid kept on Q down", pipe_valid, 1'b1);
    chk("R9 I stays on", pwr_en_i, 1'b1);
    pd_q = 1'b0; tick();
    chk("R11 valid low at Q rise", pipe_valid, 1'b0);
    repeat (HOLD - 1) tick();
    chk("R11 valid low end of Q holdoff", pipe_valid, 1'b0);
    tick();
    chk("R11 valid high after Q holdoff", pipe_valid, 1'b1);

    // R6: pd_all and cal_done together during calibration
    cal_req = 1'b1; tick();
    chk("R7 manual start", cal_start, 1'b1);
    cal_req = 1'b0; pd_all = 1'b1; cal_done = 1'b1; tick();
    cal_done = 1'b0;
    chk("R6 simultaneous pwr_en_i", pwr_en_i, 1'b0);
    chk("R11 valid low when unpowered", pipe_valid, 1'b0);

    // R8: request raised while down and held across release
    cal_req = 1'b1; tick();
    pd_all = 1'b0; tick();
    chk("R8 held req no start", cal_start, 1'b0);
    chk("R8 held req no cal", cal_en_i, 1'b0);
    chk("R8 power back", pwr_en_i, 1'b1);
    cal_req = 1'b0; tick();

    // R6: pending power-down withdrawn, calibration completes normally
    cal_req = 1'b1; tick();
    cal_req = 1'b0; pd_all = 1'b1; tick();
    chk("R6 pending keeps power", pwr_en_i, 1'b1);
    pd_all = 1'b0; tick();
    chk("R6 withdrawn still calibrating", cal_en_i, 1'b1);
    run_cal(6);
    chk("R4 done after withdraw cal_en_i", cal_en_i, 1'b0);
    chk("R4 done after withdraw pwr_en_q", pwr_en_q, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule